// File: doc/BRIEF.md
# Interrupt redirection controller

This block routes a set of interrupt input lines to a single processor-side message port. Every line owns a 64-bit redirection entry. The entry holds the vector to send, the destination ID, the active polarity, the trigger type (edge or level) and a mask. When a line becomes active, the block puts a message with the entry's vector and destination on a valid/ready delivery port.

Software never addresses an entry directly. It first writes an internal register number into an index register. It then reads or writes the selected 32-bit word through a data window. Level-triggered entries keep a pending-acceptance flag after they have sent. Only a write of the same vector to the end-of-interrupt register clears that flag, so a line that is still asserted does not flood the port. Requests that arrive together are served in fixed priority, lowest entry first.

Top module: `irq_route_ctl`

## Requirements
- R1: The bus has four register addresses, selected by `bus_addr`: 0 is the index register, 1 is the data window, 2 is end-of-interrupt (write-only, reads 0) and 3 reads 0. A write to the window goes to the internal register named by the index. `bus_rdata` shows the selected register combinationally, and the index register reads back its 8-bit value.
- R2: Entry n has its low word at index 0x10+2n and its high word at index 0x11+2n. Low-word bits are: 7:0 vector, 10:8 delivery mode, 11 destination mode, 12 delivery status, 13 polarity, 14 remote IRR, 15 trigger (1 = level) and 16 mask. The other low-word bits read 0. The high word keeps only bits 31:24, which are the destination ID.
- R3: Index 0x01 is a read-only version word: bits 23:16 give the number of entries, bits 7:0 read 0x20 and all other bits read 0.
- R4: After reset every low word reads 0x0001_0000, which means masked, and every high word reads 0.
- R5: Writes to any other index (0x00, 0x02 to 0x0F, and the indices above the table) are ignored, and reads from them return 0.
- R6: An unmasked edge entry sends its vector once for each inactive-to-active transition of its line. A transition that happens while the entry is masked is discarded and is not sent on a later unmask.
- R7: An unmasked level entry whose line is active and whose remote IRR is 0 sends its vector and sets remote IRR in the same clock. It does not send again while remote IRR is 1.
- R8: A write of vector V to the end-of-interrupt register clears remote IRR on every level entry whose vector is V. A write with any other vector leaves remote IRR unchanged.
- R9: With polarity bit 13 at 0 a line is active high; with it at 1 the line is active low.
- R10: Delivery status (bit 12) reads 1 for exactly the entry whose message is waiting on the port. It returns to 0 once the message is accepted. While `msg_valid` is high and `msg_ready` is low, the message stays unchanged.
- R11: Software writes do not change delivery status or remote IRR.
- R12: When several entries request in the same cycle, the lowest-numbered entry is sent first.
- R13: `msg_dest` carries bits 31:24 of the sending entry's high word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register select: index, window, EOI |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the selected register |
| irq_in | input | NUM_ENTRIES | Interrupt input lines, one per entry |
| msg_valid | output | 1 | A delivery message is waiting |
| msg_ready | input | 1 | The receiver accepts the message |
| msg_vector | output | 8 | Vector of the waiting message |
| msg_dest | output | 8 | Destination ID of the waiting message |

## Verification
The hardest states to reach are the ones where a level line stays asserted across remote IRR and end-of-interrupt traffic. These include an end-of-interrupt with a non-matching vector, and a matching one that must re-send at once because the line is still high. A further hard state is delivery status, which is visible only while a message is held on the port. The bench holds `msg_ready` low so that messages wait on the port. It then moves the index and reads entry words through the window while a message waits. It issues end-of-interrupt writes with the line both asserted and released. For each case it computes the expected window words and message order arithmetically from the entry number over a four-entry configuration.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;

    localparam logic [1:0] ADDR_INDEX  = 2'd0;
    localparam logic [1:0] ADDR_WINDOW = 2'd1;
    localparam logic [1:0] ADDR_EOI    = 2'd2;

    localparam logic [7:0] VER_INDEX   = 8'h01;
    localparam logic [7:0] TABLE_BASE  = 8'h10;
    localparam logic [7:0] VERSION_ID  = 8'h20;

    // per-entry state: configuration plus tracking flags
    typedef struct packed {
        logic [7:0] vector;
        logic [2:0] dmode;
        logic       dst_logical;
        logic       act_low;
        logic       lvl;
        logic       masked;
        logic [7:0] dest;
        logic       rirr;
        logic       edge_pend;
        logic       act_prev;
    } ent_state_t;

endpackage

// File: rtl/irq_route_entry.sv
module irq_route_entry
    import irq_route_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        irq_raw,
    input  logic        wr_lo,
    input  logic        wr_hi,
    input  logic [31:0] wdata,
    input  logic        eoi_wr,
    input  logic [7:0]  eoi_vec,
    input  logic        grant,
    input  logic        queued,
    output logic        req,
    output logic [31:0] lo_word,
    output logic [31:0] hi_word,
    output logic [7:0]  vector,
    output logic [7:0]  dest
);

    ent_state_t st_d, st_q;
    logic       active;
    logic       rise;
    logic       unused_wdata;

    assign unused_wdata = ^{wdata[23:17], wdata[14], wdata[12]};

    always_comb begin
        st_d   = st_q;
        active = irq_raw ^ st_q.act_low;
        rise   = active & ~st_q.act_prev;
        st_d.act_prev = active;

        if (wr_lo) begin
            st_d.vector      = wdata[7:0];
            st_d.dmode       = wdata[10:8];
            st_d.dst_logical = wdata[11];
            st_d.act_low     = wdata[13];
            st_d.lvl         = wdata[15];
            st_d.masked      = wdata[16];
        end
        if (wr_hi) begin
            st_d.dest = wdata[31:24];
        end

        // edge capture uses the mask in force when the edge happens
        if (grant && !st_q.lvl) begin
            st_d.edge_pend = 1'b0;
        end
        if (rise && !st_q.masked && !st_q.lvl) begin
            st_d.edge_pend = 1'b1;
        end

        // remote IRR: EOI clears, a new grant sets (grant wins a tie)
        if (eoi_wr && st_q.lvl && (eoi_vec == st_q.vector)) begin
            st_d.rirr = 1'b0;
        end
        if (grant && st_q.lvl) begin
            st_d.rirr = 1'b1;
        end

        if (st_q.masked) begin
            req = 1'b0;
        end else if (st_q.lvl) begin
            req = active & ~st_q.rirr;
        end else begin
            req = st_q.edge_pend;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q        <= '0;
            st_q.masked <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign lo_word = {15'd0, st_q.masked, st_q.lvl, st_q.rirr, st_q.act_low,
                      queued, st_q.dst_logical, st_q.dmode, st_q.vector};
    assign hi_word = {st_q.dest, 24'd0};
    assign vector  = st_q.vector;
    assign dest    = st_q.dest;

endmodule

// File: rtl/irq_route_pick.sv
module irq_route_pick #(
    parameter int N     = 8,
    parameter int IDX_W = 3
) (
    input  logic [N-1:0]     req,
    output logic             any,
    output logic [IDX_W-1:0] idx
);

    always_comb begin
        any = |req;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                idx = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/irq_route_ctl.sv
module irq_route_ctl
    import irq_route_pkg::*;
#(
    parameter int NUM_ENTRIES = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   bus_wr,
    input  logic [1:0]             bus_addr,
    input  logic [31:0]            bus_wdata,
    output logic [31:0]            bus_rdata,
    input  logic [NUM_ENTRIES-1:0] irq_in,
    output logic                   msg_valid,
    input  logic                   msg_ready,
    output logic [7:0]             msg_vector,
    output logic [7:0]             msg_dest
);

    localparam int IDX_W = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1;

    typedef struct packed {
        logic [7:0]       index;
        logic             valid;
        logic [7:0]       vector;
        logic [7:0]       dest;
        logic [IDX_W-1:0] src;
    } ctl_state_t;

    ctl_state_t ctl_d, ctl_q;

    logic                             win_wr;
    logic                             eoi_wr;
    logic [NUM_ENTRIES-1:0]           req_vec;
    logic [NUM_ENTRIES-1:0]           grant_vec;
    logic [NUM_ENTRIES-1:0]           status_vec;
    logic [NUM_ENTRIES-1:0]           rirr_vec;
    logic [NUM_ENTRIES-1:0][31:0]     lo_words;
    logic [NUM_ENTRIES-1:0][31:0]     hi_words;
    logic [NUM_ENTRIES-1:0][7:0]      ent_vec;
    logic [NUM_ENTRIES-1:0][7:0]      ent_dest;
    logic                             pick_any;
    logic [IDX_W-1:0]                 pick_idx;
    logic [31:0]                      win_rd;

    assign win_wr = bus_wr && (bus_addr == ADDR_WINDOW);
    assign eoi_wr = bus_wr && (bus_addr == ADDR_EOI);

    for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_ent
        localparam logic [7:0] LO_IX = TABLE_BASE + 8'(2 * g);
        localparam logic [7:0] HI_IX = TABLE_BASE + 8'(2 * g + 1);

        assign status_vec[g] = ctl_q.valid && (ctl_q.src == IDX_W'(g));
        assign rirr_vec[g]   = lo_words[g][14];

        irq_route_entry u_ent (
            .clk     (clk),
            .rst_n   (rst_n),
            .irq_raw (irq_in[g]),
            .wr_lo   (win_wr && (ctl_q.index == LO_IX)),
            .wr_hi   (win_wr && (ctl_q.index == HI_IX)),
            .wdata   (bus_wdata),
            .eoi_wr  (eoi_wr),
            .eoi_vec (bus_wdata[7:0]),
            .grant   (grant_vec[g]),
            .queued  (status_vec[g]),
            .req     (req_vec[g]),
            .lo_word (lo_words[g]),
            .hi_word (hi_words[g]),
            .vector  (ent_vec[g]),
            .dest    (ent_dest[g])
        );
    end

    irq_route_pick #(
        .N     (NUM_ENTRIES),
        .IDX_W (IDX_W)
    ) u_pick (
        .req (req_vec),
        .any (pick_any),
        .idx (pick_idx)
    );

    // window read decode
    always_comb begin
        win_rd = '0;
        if (ctl_q.index == VER_INDEX) begin
            win_rd = {8'd0, 8'(NUM_ENTRIES), 8'd0, VERSION_ID};
        end
        for (int n = 0; n < NUM_ENTRIES; n++) begin
            if (ctl_q.index == (TABLE_BASE + 8'(2 * n))) begin
                win_rd = lo_words[n];
            end
            if (ctl_q.index == (TABLE_BASE + 8'(2 * n + 1))) begin
                win_rd = hi_words[n];
            end
        end
    end

    always_comb begin
        case (bus_addr)
            ADDR_INDEX:  bus_rdata = {24'd0, ctl_q.index};
            ADDR_WINDOW: bus_rdata = win_rd;
            default:     bus_rdata = '0;
        endcase
    end

    // next state: index register and the delivery slot
    always_comb begin
        ctl_d     = ctl_q;
        grant_vec = '0;
        if (bus_wr && (bus_addr == ADDR_INDEX)) begin
            ctl_d.index = bus_wdata[7:0];
        end
        if (ctl_q.valid) begin
            if (msg_ready) begin
                ctl_d.valid = 1'b0;
            end
        end else if (pick_any) begin
            ctl_d.valid         = 1'b1;
            ctl_d.vector        = ent_vec[pick_idx];
            ctl_d.dest          = ent_dest[pick_idx];
            ctl_d.src           = pick_idx;
            grant_vec[pick_idx] = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign msg_valid  = ctl_q.valid;
    assign msg_vector = ctl_q.vector;
    assign msg_dest   = ctl_q.dest;

endmodule

// File: rtl/irq_route_ctl_chk.sv
module irq_route_ctl_chk #(
    parameter int NUM_ENTRIES = 8
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   msg_valid,
    input logic                   msg_ready,
    input logic [7:0]             msg_vector,
    input logic [7:0]             msg_dest,
    input logic [NUM_ENTRIES-1:0] status_vec,
    input logic [NUM_ENTRIES-1:0] rirr_vec,
    input logic                   eoi_wr
);

    assert_msg_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && !msg_ready) |=>
            (msg_valid && $stable(msg_vector) && $stable(msg_dest)));

    assert_status_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
        msg_valid |-> ($countones(status_vec) == 1));

    assert_status_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !msg_valid |-> (status_vec == '0));

    assert_rirr_set_on_send_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (|(rirr_vec & ~$past(rirr_vec))) |-> (msg_valid && !$past(msg_valid)));

    assert_rirr_clear_by_eoi_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (|($past(rirr_vec) & ~rirr_vec)) |-> $past(eoi_wr));

endmodule

bind irq_route_ctl irq_route_ctl_chk #(.NUM_ENTRIES(NUM_ENTRIES)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .msg_valid  (msg_valid),
    .msg_ready  (msg_ready),
    .msg_vector (msg_vector),
    .msg_dest   (msg_dest),
    .status_vec (status_vec),
    .rirr_vec   (rirr_vec),
    .eoi_wr     (eoi_wr)
);

// File: tb/irq_route_ctl_tb_top.sv
`timescale 1ns/1ps
module irq_route_ctl_tb_top;

    localparam int N = 4;
    localparam logic [31:0] LO_RW = 32'hFF | (32'h7 << 8) | (32'h1 << 11)
                                  | (32'h1 << 13) | (32'h1 << 15) | (32'h1 << 16);
    localparam logic [31:0] BIT_MASK = 32'h1 << 16;
    localparam logic [31:0] BIT_LVL  = 32'h1 << 15;
    localparam logic [31:0] BIT_LOW  = 32'h1 << 13;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [1:0]  bus_addr = 2'd0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [N-1:0] irq_in = '0;
    logic        msg_valid;
    logic        msg_ready = 1'b0;
    logic [7:0]  msg_vector;
    logic [7:0]  msg_dest;

    int n_cmp = 0;
    int n_err = 0;

    always #10 clk = ~clk;

    irq_route_ctl #(.NUM_ENTRIES(N)) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_wr     (bus_wr),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .irq_in     (irq_in),
        .msg_valid  (msg_valid),
        .msg_ready  (msg_ready),
        .msg_vector (msg_vector),
        .msg_dest   (msg_dest)
    );

    function automatic logic [7:0] vec_of(input int n);
        return 8'(8'h30 + 5 * n);
    endfunction
    function automatic logic [7:0] dst_of(input int n);
        return 8'(8'hA0 + n);
    endfunction
    function automatic logic [7:0] lo_ix(input int n);
        return 8'(8'h10 + 2 * n);
    endfunction

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        n_cmp++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic bus_w(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic win_w(input logic [7:0] ix, input logic [31:0] d);
        bus_w(2'd0, {24'd0, ix});
        bus_w(2'd1, d);
    endtask

    task automatic win_r(input logic [7:0] ix, output logic [31:0] d);
        bus_w(2'd0, {24'd0, ix});
        bus_addr = 2'd1;
        #1;
        d = bus_rdata;
    endtask

    task automatic wait_msg(output logic got);
        got = 1'b0;
        for (int i = 0; i < 20 && !got; i++) begin
            @(negedge clk);
            if (msg_valid) got = 1'b1;
        end
    endtask

    task automatic accept();
        @(negedge clk);
        msg_ready = 1'b1;
        @(negedge clk);
        msg_ready = 1'b0;
    endtask

    task automatic no_msg(input int cyc, input string tag);
        logic seen;
        seen = 1'b0;
        for (int i = 0; i < cyc; i++) begin
            @(negedge clk);
            if (msg_valid) seen = 1'b1;
        end
        chk({31'd0, seen}, 32'd0, tag);
    endtask

    task automatic expect_msg(input int n, input string tag);
        logic got;
        wait_msg(got);
        chk({31'd0, got}, 32'd1, tag);
        chk({24'd0, msg_vector}, {24'd0, vec_of(n)}, tag);
        chk({24'd0, msg_dest}, {24'd0, dst_of(n)}, {tag, " R13"});
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        logic [31:0] rd;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R4 / R2: reset contents of every entry
        for (int n = 0; n < N; n++) begin
            win_r(lo_ix(n), rd);     chk(rd, 32'h0001_0000, "R4 low word");
            win_r(lo_ix(n) + 1, rd); chk(rd, 32'h0, "R4 high word");
        end
        chk({31'd0, msg_valid}, 32'd0, "R4 no message after reset");

        // R3: version word
        win_r(8'h01, rd);
        chk(rd, (32'(N) << 16) | 32'h20, "R3 version");

        // R1: index register reads back
        bus_w(2'd0, 32'h0000_005A);
        bus_addr = 2'd0; #1;
        chk(bus_rdata, 32'h5A, "R1 index readback");
        bus_addr = 2'd2; #1;
        chk(bus_rdata, 32'h0, "R1 EOI reads zero");

        // R5: sweep every unimplemented index
        for (int ix = 0; ix < 256; ix++) begin
            if (ix == 1 || (ix >= 16 && ix < 16 + 2 * N)) continue;
            win_w(8'(ix), 32'hFFFF_FFFF);
            bus_addr = 2'd1; #1;
            chk(bus_rdata, 32'h0, "R5 unimplemented read");
        end
        for (int n = 0; n < N; n++) begin
            win_r(lo_ix(n), rd); chk(rd, 32'h0001_0000, "R5 entries untouched");
        end

        // R11 / R2: all-ones write, read-only bits stay zero
        irq_in = '1;
        for (int n = 0; n < N; n++) begin
            win_w(lo_ix(n), 32'hFFFF_FFFF);
            win_r(lo_ix(n), rd);     chk(rd, LO_RW, "R11 low write mask");
            win_w(lo_ix(n) + 1, 32'hFFFF_FFFF);
            win_r(lo_ix(n) + 1, rd); chk(rd, 32'hFF00_0000, "R2 high word");
            win_w(lo_ix(n), BIT_MASK);
            win_w(lo_ix(n) + 1, {dst_of(n), 24'd0});
        end
        irq_in = '0;
        no_msg(4, "R11 masked entries silent");

        // R6 / R10: edge delivery on every entry
        for (int n = 0; n < N; n++) begin
            win_w(lo_ix(n), {24'd0, vec_of(n)});
            @(negedge clk); irq_in[n] = 1'b1;
            repeat (3) @(negedge clk); irq_in[n] = 1'b0;
            expect_msg(n, "R6 edge message");
            win_r(lo_ix(n), rd);
            chk((rd >> 12) & 32'h1, 32'h1, "R10 status while waiting");
            chk({24'd0, msg_vector}, {24'd0, vec_of(n)}, "R10 message held");
            accept();
            no_msg(6, "R6 single send per edge");
            win_r(lo_ix(n), rd);
            chk(rd, {24'd0, vec_of(n)}, "R10 status cleared");
            win_w(lo_ix(n), BIT_MASK | vec_of(n));
        end

        // R6: edge while masked is dropped
        win_w(lo_ix(0), BIT_MASK | vec_of(0));
        @(negedge clk); irq_in[0] = 1'b1;
        repeat (2) @(negedge clk); irq_in[0] = 1'b0;
        win_w(lo_ix(0), {24'd0, vec_of(0)});
        no_msg(8, "R6 masked edge dropped");
        win_w(lo_ix(0), BIT_MASK | vec_of(0));

        // R7 / R8: level entries with remote IRR
        for (int n = 0; n < N; n++) begin
            win_w(lo_ix(n), BIT_LVL | vec_of(n));
            irq_in[n] = 1'b1;
            expect_msg(n, "R7 level message");
            accept();
            win_r(lo_ix(n), rd);
            chk((rd >> 14) & 32'h1, 32'h1, "R7 remote IRR set");
            no_msg(6, "R7 no repeat while IRR");
            bus_w(2'd2, {24'd0, vec_of(n) ^ 8'h01});
            no_msg(4, "R8 wrong EOI ignored");
            win_r(lo_ix(n), rd);
            chk((rd >> 14) & 32'h1, 32'h1, "R8 IRR kept on wrong EOI");
            bus_w(2'd2, {24'd0, vec_of(n)});
            expect_msg(n, "R8 resend after EOI");
            accept();
            irq_in[n] = 1'b0;
            bus_w(2'd2, {24'd0, vec_of(n)});
            no_msg(5, "R8 no send after release");
            win_r(lo_ix(n), rd);
            chk(rd, BIT_LVL | vec_of(n), "R8 IRR cleared");
            win_w(lo_ix(n), BIT_MASK | vec_of(n));
        end

        // R9: active-low level entry
        irq_in[2] = 1'b1;
        win_w(lo_ix(2), BIT_LVL | BIT_LOW | vec_of(2));
        no_msg(5, "R9 high is inactive");
        irq_in[2] = 1'b0;
        expect_msg(2, "R9 low is active");
        accept();
        irq_in[2] = 1'b1;
        bus_w(2'd2, {24'd0, vec_of(2)});
        no_msg(5, "R9 released line silent");
        win_w(lo_ix(2), BIT_MASK | vec_of(2));
        irq_in[2] = 1'b0;

        // R12: all level entries raised together
        for (int n = 0; n < N; n++) win_w(lo_ix(n), BIT_LVL | vec_of(n));
        @(negedge clk); irq_in = '1;
        for (int n = 0; n < N; n++) begin
            expect_msg(n, "R12 priority order");
            accept();
        end
        irq_in = '0;
        for (int n = 0; n < N; n++) bus_w(2'd2, {24'd0, vec_of(n)});
        no_msg(5, "R12 quiet after release");

        summary();
        $finish;
    end

endmodule